// File: doc/BRIEF.md
# ATA Task-File Register Block (Device Side)

This block is the register face of an ATA device as seen by a host through an eight-location byte-wide I/O window. The host loads the parameter registers (feature, sector count, three address bytes, device select), then writes an opcode to the command location. The block reports progress through a status byte and an error byte, and it drives an interrupt line that a status read acknowledges.

A small state machine runs three commands. The first returns 256 identification words on the data port, fetched from an external constant word ROM through an index/word port. The second is a self-test command that forces the device-select bit back to zero. The third is a cache flush that keeps the device busy until a back-end handshake reports done (or done with error). Any other opcode is rejected at once with an abort.

States: `ST_IDLE` (ready, no data), `ST_DATA_IN` (identification words pending, DRQ high), `ST_FLUSH` (busy, waiting for the back end). Transitions: IDLE/DATA_IN → DATA_IN on the identify opcode; IDLE/DATA_IN → IDLE on self-test or an unknown opcode; IDLE/DATA_IN → FLUSH on the flush opcode; DATA_IN → IDLE on the read of the last word; FLUSH → IDLE on `flush_done`.

Top module: `ata_taskfile`

## Requirements
- R1: After reset the status byte reads 0x40, the error byte reads 0x00, the parameter registers read 0x00, and `irq` and `flush_req` are low.
- R2: Writes to offsets 1 to 6 load feature, sector count, address low/mid/high and device registers; reads of offsets 2 to 6 return the last value written; a read of offset 1 returns the error byte, not the feature.
- R3: Status bit positions are BSY=bit 7, DRDY=bit 6, DF=bit 5, DRQ=bit 3, ERR=bit 0; DRDY is always 1 and DF always 0 out of reset, and BSY and DRQ are never both set.
- R4: A read of offset 7 (status) deasserts `irq` at the next clock edge; reads of other offsets leave `irq` unchanged.
- R5: Opcode 0xEC raises `irq` and sets DRQ; each read of offset 0 returns the ROM word at the current index (starting at 0, ascending, index shown on `id_addr`), and status reads 0x48 before every word.
- R6: The read of word 255 clears DRQ (status back to 0x40); a read of offset 0 outside the data phase returns 0 and advances nothing.
- R7: An opcode other than 0xEC, 0x90 and 0xE7 sets ERR (status 0x41), sets ABRT (error byte 0x04, bit 2) and raises `irq` in the next cycle.
- R8: Opcode 0x90 clears bit 4 (device select) of the device register, keeps its other bits, leaves status 0x40 and raises `irq`.
- R9: Opcode 0xE7 shows status 0xC0 and holds `flush_req` high until `flush_done`; then status is 0x40, `flush_req` is low and `irq` is raised.
- R10: `flush_done` together with `flush_err` ends the flush with status 0x41 and error byte 0x04.
- R11: While BSY is 1 every register write, command writes included, is ignored.
- R12: Every accepted command clears ERR and ABRT left by an earlier command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset in the I/O window |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access (side effects on its edge) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 16 | Read data for the addressed offset (combinational) |
| irq | output | 1 | Interrupt request |
| id_addr | output | 8 | Index of the identification word to present |
| id_word | input | 16 | Identification word for `id_addr` |
| flush_req | output | 1 | Flush request to the back end, high while busy |
| flush_done | input | 1 | Back end finished the flush |
| flush_err | input | 1 | Flush failed, qualified by `flush_done` |

## Verification
The bench goes after the word-count boundary of the data phase: a design that clears DRQ one word early or late either truncates the identification block or leaves the host stuck with DRQ set after word 255. It checks that a status read, and only a status read, drops the interrupt, which an off-by-offset decode would get wrong by acknowledging on parameter reads. It writes both a parameter and a new command while the flush is busy and expects both to vanish, and it follows a failed flush with a good command to catch an ERR bit that never clears. The self-test check starts with the device bit set alongside other bits, so a design that zeroes the whole register is caught.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DATA_IN = 2'd1,
        ST_FLUSH   = 2'd2
    } seq_state_t;

    // register offsets
    localparam logic [2:0] OFS_DATA    = 3'd0;
    localparam logic [2:0] OFS_ERRFEAT = 3'd1;
    localparam logic [2:0] OFS_DEVSEL  = 3'd6;
    localparam logic [2:0] OFS_CMDSTAT = 3'd7;

    // number of plain parameter registers, offsets 1..6
    localparam int NUM_PARAM = 6;

    // opcodes
    localparam logic [7:0] OP_IDENTIFY = 8'hEC;
    localparam logic [7:0] OP_SELFTEST = 8'h90;
    localparam logic [7:0] OP_FLUSH    = 8'hE7;

    // bit positions
    localparam int BIT_BSY   = 7;
    localparam int BIT_DRDY  = 6;
    localparam int BIT_DF    = 5;
    localparam int BIT_DRQ   = 3;
    localparam int BIT_ERR   = 0;
    localparam int BIT_ABRT  = 2;
    localparam int BIT_DEVNO = 4;

endpackage

// File: rtl/ata_tf_regs.sv
module ata_tf_regs
    import ata_tf_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [2:0]                      wr_addr,
    input  logic [REG_W-1:0]                wr_data,
    input  logic                            devsel_clr,
    output logic [NUM_PARAM-1:0][REG_W-1:0] regs_q
);

    // offset k+1 is held in slot k
    for (genvar k = 0; k < NUM_PARAM; k++) begin : g_param
        localparam logic [2:0] MY_OFS = 3'(k + 1);
        if (MY_OFS == OFS_DEVSEL) begin : g_dev
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    regs_q[k] <= '0;
                end else if (wr_en && wr_addr == MY_OFS) begin
                    regs_q[k] <= wr_data;
                end else if (devsel_clr) begin
                    regs_q[k][BIT_DEVNO] <= 1'b0;
                end
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    regs_q[k] <= '0;
                end else if (wr_en && wr_addr == MY_OFS) begin
                    regs_q[k] <= wr_data;
                end
            end
        end
    end

endmodule

// File: rtl/ata_tf_seq.sv
module ata_tf_seq
    import ata_tf_pkg::*;
#(
    parameter int ID_WORDS = 256,
    parameter int IDX_W    = 8,
    parameter int REG_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [REG_W-1:0] opcode,
    input  logic             data_rd,
    input  logic             stat_rd,
    input  logic             flush_done,
    input  logic             flush_err,
    output logic [REG_W-1:0] status,
    output logic             abrt,
    output logic             drq,
    output logic             irq,
    output logic             devsel_clr,
    output logic             flush_req,
    output logic [IDX_W-1:0] word_idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ID_WORDS - 1);

    seq_state_t       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             err_q, err_d;
    logic             abrt_q, abrt_d;
    logic             irq_q, irq_d;
    logic             irq_set;
    logic             bsy;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            err_q   <= 1'b0;
            abrt_q  <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            err_q   <= err_d;
            abrt_q  <= abrt_d;
            irq_q   <= irq_d;
        end
    end

    // next state
    always_comb begin
        state_d    = state_q;
        idx_d      = idx_q;
        err_d      = err_q;
        abrt_d     = abrt_q;
        irq_set    = 1'b0;
        devsel_clr = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_DATA_IN: begin
                if (cmd_wr) begin
                    err_d  = 1'b0;
                    abrt_d = 1'b0;
                    case (opcode)
                        OP_IDENTIFY: begin
                            state_d = ST_DATA_IN;
                            idx_d   = '0;
                            irq_set = 1'b1;
                        end
                        OP_SELFTEST: begin
                            state_d    = ST_IDLE;
                            devsel_clr = 1'b1;
                            irq_set    = 1'b1;
                        end
                        OP_FLUSH: begin
                            state_d = ST_FLUSH;
                        end
                        default: begin
                            state_d = ST_IDLE;
                            err_d   = 1'b1;
                            abrt_d  = 1'b1;
                            irq_set = 1'b1;
                        end
                    endcase
                end else if (state_q == ST_DATA_IN && data_rd) begin
                    idx_d = idx_q + 1'b1;
                    if (idx_q == LAST_IDX) begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_FLUSH: begin
                if (flush_done) begin
                    state_d = ST_IDLE;
                    err_d   = flush_err;
                    abrt_d  = flush_err;
                    irq_set = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        irq_d = irq_set | (irq_q & ~stat_rd);
    end

    // outputs
    always_comb begin
        bsy       = (state_q == ST_FLUSH);
        drq       = (state_q == ST_DATA_IN);
        flush_req = bsy;
        status    = '0;
        status[BIT_BSY]  = bsy;
        status[BIT_DRDY] = 1'b1;
        status[BIT_DF]   = 1'b0;
        status[BIT_DRQ]  = drq;
        status[BIT_ERR]  = err_q;
        abrt      = abrt_q;
        irq       = irq_q;
        word_idx  = idx_q;
    end

endmodule

// File: rtl/ata_tf_rdmux.sv
module ata_tf_rdmux
    import ata_tf_pkg::*;
#(
    parameter int REG_W  = 8,
    parameter int WORD_W = 16
) (
    input  logic [2:0]                      rd_addr,
    input  logic [NUM_PARAM-1:0][REG_W-1:0] regs_q,
    input  logic [REG_W-1:0]                status,
    input  logic                            abrt,
    input  logic                            drq,
    input  logic [WORD_W-1:0]               id_word,
    output logic [WORD_W-1:0]               rdata
);

    logic [REG_W-1:0] err_byte;

    always_comb begin
        err_byte           = '0;
        err_byte[BIT_ABRT] = abrt;
        unique case (rd_addr)
            OFS_DATA:    rdata = drq ? id_word : '0;
            OFS_ERRFEAT: rdata = WORD_W'(err_byte);
            OFS_CMDSTAT: rdata = WORD_W'(status);
            default:     rdata = WORD_W'(regs_q[rd_addr - 3'd1]);
        endcase
    end

endmodule

// File: rtl/ata_taskfile.sv
module ata_taskfile
    import ata_tf_pkg::*;
#(
    parameter int REG_W    = 8,
    parameter int WORD_W   = 16,
    parameter int ID_WORDS = 256,
    localparam int IDX_W   = $clog2(ID_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq,
    output logic [IDX_W-1:0]  id_addr,
    input  logic [WORD_W-1:0] id_word,
    output logic              flush_req,
    input  logic              flush_done,
    input  logic              flush_err
);

    logic [NUM_PARAM-1:0][REG_W-1:0] tf_q;
    logic [REG_W-1:0]                stat_byte;
    logic                            abrt;
    logic                            drq;
    logic                            devsel_clr;
    logic                            busy;
    logic                            param_wr;
    logic                            cmd_wr;

    assign busy     = stat_byte[BIT_BSY];
    assign param_wr = bus_wr && !busy && bus_addr != OFS_CMDSTAT && bus_addr != OFS_DATA;
    assign cmd_wr   = bus_wr && !busy && bus_addr == OFS_CMDSTAT;

    ata_tf_regs #(.REG_W(REG_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (param_wr),
        .wr_addr    (bus_addr),
        .wr_data    (bus_wdata),
        .devsel_clr (devsel_clr),
        .regs_q     (tf_q)
    );

    ata_tf_seq #(.ID_WORDS(ID_WORDS), .IDX_W(IDX_W), .REG_W(REG_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr     (cmd_wr),
        .opcode     (bus_wdata),
        .data_rd    (bus_rd && bus_addr == OFS_DATA),
        .stat_rd    (bus_rd && bus_addr == OFS_CMDSTAT),
        .flush_done (flush_done),
        .flush_err  (flush_err),
        .status     (stat_byte),
        .abrt       (abrt),
        .drq        (drq),
        .irq        (irq),
        .devsel_clr (devsel_clr),
        .flush_req  (flush_req),
        .word_idx   (id_addr)
    );

    ata_tf_rdmux #(.REG_W(REG_W), .WORD_W(WORD_W)) u_rdmux (
        .rd_addr (bus_addr),
        .regs_q  (tf_q),
        .status  (stat_byte),
        .abrt    (abrt),
        .drq     (drq),
        .id_word (id_word),
        .rdata   (bus_rdata)
    );

endmodule

// File: rtl/ata_taskfile_chk.sv
module ata_taskfile_chk #(
    parameter int REG_W = 8,
    parameter int IDX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       bus_addr,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic             flush_done,
    input logic             irq,
    input logic             flush_req,
    input logic [IDX_W-1:0] id_addr,
    input logic [REG_W-1:0] status,
    input logic [REG_W-1:0] count_reg
);

    localparam logic [IDX_W-1:0] LAST_IDX = '1;

    assert_status_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        status[6] && !status[5] && !(status[7] && status[3]));

    assert_ack_on_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd7 && !bus_wr && !flush_done) |=> !irq);

    assert_irq_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(bus_wr && bus_addr == 3'd7) || $past(flush_done)));

    assert_last_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (status[3] && bus_rd && bus_addr == 3'd0 && id_addr == LAST_IDX && !bus_wr) |=> !status[3]);

    assert_flush_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> (status[7] && !status[3] && !status[0]));

    assert_busy_write_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (status[7] && bus_wr && bus_addr == 3'd2) |=> $stable(count_reg));

endmodule

bind ata_taskfile ata_taskfile_chk #(.REG_W(REG_W), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .flush_done (flush_done),
    .irq        (irq),
    .flush_req  (flush_req),
    .id_addr    (id_addr),
    .status     (stat_byte),
    .count_reg  (tf_q[1])
);

// File: tb/ata_taskfile_tb.sv
module ata_taskfile_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;
    logic [7:0]  id_addr;
    logic [15:0] id_word;
    logic        flush_req;
    logic        flush_done = 1'b0;
    logic        flush_err = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    // identification ROM model: word i = {i ^ A5, i}
    assign id_word = {id_addr ^ 8'hA5, id_addr};

    ata_taskfile u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq        (irq),
        .id_addr    (id_addr),
        .id_word    (id_word),
        .flush_req  (flush_req),
        .flush_done (flush_done),
        .flush_err  (flush_err)
    );

    // {offset, write value, expected read value}
    localparam logic [23:0] VEC [0:5] = '{
        24'h02_5A_5A,
        24'h03_11_11,
        24'h04_22_22,
        24'h05_FF_FF,
        24'h06_E0_E0,
        24'h01_03_00
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic finish_flush(input logic with_err);
        @(negedge clk);
        flush_done = 1'b1;
        flush_err  = with_err;
        @(negedge clk);
        flush_done = 1'b0;
        flush_err  = 1'b0;
    endtask

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        rd(3'd7, v); check("R1/R3 reset status", v, 16'h0040);
        rd(3'd1, v); check("R1 reset error", v, 16'h0000);
        rd(3'd4, v); check("R1 reset lba mid", v, 16'h0000);
        check("R1 reset irq", {15'd0, irq}, 16'd0);
        check("R1 reset flush_req", {15'd0, flush_req}, 16'd0);

        // register round trip table
        for (int i = 0; i < 6; i++) begin
            wr(VEC[i][18:16], VEC[i][15:8]);
            rd(VEC[i][18:16], v);
            check("R2 register readback", v, {8'h00, VEC[i][7:0]});
        end

        // unsupported opcode
        wr(3'd7, 8'h27);
        check("R7 abort irq", {15'd0, irq}, 16'd1);
        rd(3'd1, v); check("R7 abort error byte", v, 16'h0004);
        check("R4 non-status read keeps irq", {15'd0, irq}, 16'd1);
        rd(3'd7, v); check("R7 abort status", v, 16'h0041);
        check("R4 status read clears irq", {15'd0, irq}, 16'd0);

        // identify
        wr(3'd7, 8'hEC);
        check("R5 identify irq", {15'd0, irq}, 16'd1);
        rd(3'd1, v); check("R12 identify clears abort", v, 16'h0000);
        for (int i = 0; i < 256; i++) begin
            rd(3'd7, v); check("R5 status before word", v, 16'h0048);
            rd(3'd0, v); check("R5 identify word", v, {8'(i) ^ 8'hA5, 8'(i)});
        end
        rd(3'd7, v); check("R6 status after last word", v, 16'h0040);
        rd(3'd0, v); check("R6 idle data read", v, 16'h0000);

        // flush with busy writes
        wr(3'd7, 8'hE7);
        rd(3'd7, v); check("R9 flush busy status", v, 16'h00C0);
        check("R9 flush_req high", {15'd0, flush_req}, 16'd1);
        wr(3'd2, 8'h77);
        wr(3'd7, 8'hEC);
        rd(3'd2, v); check("R11 busy write ignored", v, 16'h005A);
        finish_flush(1'b0);
        check("R9 flush done irq", {15'd0, irq}, 16'd1);
        check("R9 flush_req low", {15'd0, flush_req}, 16'd0);
        rd(3'd7, v); check("R9/R11 status after flush", v, 16'h0040);

        // flush failing
        wr(3'd7, 8'hE7);
        finish_flush(1'b1);
        rd(3'd7, v); check("R10 failed flush status", v, 16'h0041);
        rd(3'd1, v); check("R10 failed flush error", v, 16'h0004);

        // self-test
        wr(3'd6, 8'h50);
        rd(3'd6, v); check("R2 device select set", v, 16'h0050);
        wr(3'd7, 8'h90);
        check("R8 selftest irq", {15'd0, irq}, 16'd1);
        rd(3'd6, v); check("R8 device bit cleared", v, 16'h0040);
        rd(3'd7, v); check("R12 error cleared by next command", v, 16'h0040);
        rd(3'd1, v); check("R12 abort cleared", v, 16'h0000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule